// File: doc/BRIEF.md
# Parallel Flash Bus-Mode Controller

This block sits on the host side of an asynchronous parallel flash array and turns the three active-low strobes (chip enable, output enable, write enable) into read, write and idle cycles, all sampled on a free-running clock. A small internal register file stands in for the storage array. A counter stands in for the program engine: while it runs, the ready/busy output is low.

A hardware reset pin is filtered for a minimum low width. A pulse that is long enough aborts a program in progress and returns the command state to plain array reads. If a program was aborted, ready/busy is held low for a ready delay. The output drivers stay off for a recovery window after the pin is released. A byte-mode pin chooses a 16-bit bus or an 8-bit bus. In 8-bit mode the top data line becomes the lowest address bit and picks which half of the word appears on the low byte lane. When the address has not changed for a set number of samples, the block sleeps and keeps its output data frozen. An identification mode returns two fixed codes in place of array data.

Top module: `pflash_bus_ctrl`

## Requirements
- R1: A read cycle is one in which ce_n=0, oe_n=0 and we_n=1 are sampled at a clock edge, with hw_rst_n high and no recovery window pending. After that edge dq_oe is non-zero and dq_out carries the addressed data. Any other sample drives dq_oe to 0 after the edge.
- R2: A write cycle is one in which ce_n=0, we_n=0 and oe_n=1 are sampled. A write is acted on only at the first sample of the cycle, and only while hw_rst_n is high and ready is high. The command byte is dq_in[7:0]. 0xF0 selects array reads, 0x90 selects identification reads, and 0xA0 arms a program. The write that follows an arming write programs the data it carries at its address. Any other byte changes nothing.
- R3: After rst_n, the block reads the array and the whole array is zero. ready=1, sleep=0 and dq_oe=0.
- R4: hw_rst_n is accepted as a reset only at the edge of its MIN_RST-th consecutive low sample. A shorter pulse leaves a program running and leaves the mode unchanged. An accepted reset returns the block to array reads.
- R5: While hw_rst_n is sampled low, dq_oe is 0 after the edge and write cycles are ignored.
- R6: An accepted reset during a program cancels it and leaves the word unchanged. ready is then low for exactly READY_CYC samples after the accepting edge. An accepted reset while ready=1 keeps ready high.
- R7: After hw_rst_n returns high, the first RECOV_CYC high samples give dq_oe=0 even in a read cycle.
- R8: A program holds ready low for PROG_CYC samples, starting with the edge that accepts its data write. The word is updated at the last of those edges. Writes made while ready is low are ignored.
- R9: The tracked vector is {byte_n, addr, A-1}. When it is unchanged for SLEEP_CYC consecutive samples, sleep is 1 and dq_out stays frozen. Any of the following clears sleep and its count at the edge where it occurs: a change of the vector, the first sample of a write cycle, the end of a program, or an accepted reset.
- R10: With byte_n=0, dq_in[15] acts as address bit A-1. A-1=1 puts the high half of the word on dq_out[7:0] and A-1=0 puts the low half there. dq_out[15:8] is 0 and dq_oe[1] is 0. A program writes only the selected byte, using the data on dq_in[7:0].
- R11: In identification mode, a read of an even address returns MFG_CODE and a read of an odd address returns DEV_CODE. The code is on dq_out[7:0] and dq_out[15:8] is 0.
- R12: If a reset is accepted at the same edge as a program's last busy cycle, the abort wins: the word is unchanged and ready is low for READY_CYC samples.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | sampling clock |
| rst_n | input | 1 | synchronous active-low power-up reset |
| hw_rst_n | input | 1 | hardware reset pin, active low, filtered for width |
| ce_n | input | 1 | chip enable, active low |
| oe_n | input | 1 | output enable, active low |
| we_n | input | 1 | write enable, active low |
| byte_n | input | 1 | 1: 16-bit bus, 0: 8-bit bus |
| addr | input | AW | word address |
| dq_in | input | 16 | data in; bit 15 is address A-1 when byte_n=0 |
| dq_out | output | 16 | registered read data |
| dq_oe | output | 2 | per-lane drive enable, bit 0 low byte, bit 1 high byte |
| ready | output | 1 | ready/busy, 0 while busy |
| sleep | output | 1 | 1 while in address-stable sleep |

## Verification
Two collisions are provoked on purpose. In the first, a reset pulse is timed so that its MIN_RST-th low sample falls on the edge where a program would commit. The bench then expects the word to stay unchanged and ready to stay low for the full ready delay. In the second, a reset is held, released and timed against an identification-mode read cycle that is kept asserted throughout. This checks that the recovery window, the tri-state during reset and the return to array reads all line up cycle by cycle. A behavioural model is advanced on every edge and compared with ready, sleep, dq_oe and dq_out, so a collision that is resolved the wrong way shows up in the cycle where it happens.

// File: rtl/pfb_pkg.sv
// pfb_pkg: shared mode type and command byte codes for the bus-mode controller.
// Assumes: command bytes arrive on the low byte lane.
package pfb_pkg;
    typedef enum logic [1:0] {
        MODE_ARRAY = 2'd0,
        MODE_IDENT = 2'd1,
        MODE_ARMED = 2'd2
    } pfb_mode_e;

    localparam logic [7:0] CMD_TO_ARRAY = 8'hF0;
    localparam logic [7:0] CMD_TO_IDENT = 8'h90;
    localparam logic [7:0] CMD_ARM_PROG = 8'hA0;
endpackage

// File: rtl/pfb_rst_filter.sv
// pfb_rst_filter: width filter for the hardware reset pin, plus the read
// recovery window that follows release.
// Assumes: pin_n is synchronous to clk; MIN_LOW >= 1, RECOV >= 1.
module pfb_rst_filter #(
    parameter int MIN_LOW = 4,
    parameter int RECOV   = 3
) (
    input  logic clk,
    input  logic rst_n,
    input  logic pin_n,
    output logic accept,
    output logic rd_block
);
    localparam int LW = $clog2(MIN_LOW + 1);
    localparam int RW = $clog2(RECOV + 1);

    logic [LW-1:0] low_cnt;
    logic [RW-1:0] rec_cnt;

    // Pulse on the edge of the MIN_LOW-th consecutive low sample.
    assign accept   = !pin_n && (low_cnt == LW'(MIN_LOW - 1));
    // Reads are blocked while the pin is low and during recovery.
    assign rd_block = !pin_n || (rec_cnt != '0);

    // Count consecutive low samples, saturating at MIN_LOW.
    always_ff @(posedge clk) begin
        if (!rst_n)                      low_cnt <= '0;
        else if (pin_n)                  low_cnt <= '0;
        else if (low_cnt != LW'(MIN_LOW)) low_cnt <= low_cnt + 1'b1;
    end

    // Reload recovery while low, count down once released.
    always_ff @(posedge clk) begin
        if (!rst_n)              rec_cnt <= '0;
        else if (!pin_n)         rec_cnt <= RW'(RECOV);
        else if (rec_cnt != '0)  rec_cnt <= rec_cnt - 1'b1;
    end
endmodule

// File: rtl/pfb_busy_ctrl.sv
// pfb_busy_ctrl: program-engine stand-in with a fixed busy time, and the
// post-abort ready delay.
// Assumes: start is only raised while ready is high.
module pfb_busy_ctrl #(
    parameter int PROG_CYC  = 16,
    parameter int READY_CYC = 10
) (
    input  logic clk,
    input  logic rst_n,
    input  logic start,
    input  logic abort,
    output logic busy,
    output logic done,
    output logic ready
);
    localparam int PW = $clog2(PROG_CYC + 1);
    localparam int DW = $clog2(READY_CYC + 1);

    logic [PW-1:0] prog_cnt;
    logic [DW-1:0] rdy_cnt;

    assign busy  = (prog_cnt != '0);
    // The final busy edge commits the program unless an abort lands on it.
    assign done  = (prog_cnt == PW'(1)) && !abort;
    assign ready = !busy && (rdy_cnt == '0);

    // Program busy counter: load on start, clear on abort.
    always_ff @(posedge clk) begin
        if (!rst_n)        prog_cnt <= '0;
        else if (abort)    prog_cnt <= '0;
        else if (start)    prog_cnt <= PW'(PROG_CYC);
        else if (busy)     prog_cnt <= prog_cnt - 1'b1;
    end

    // Ready delay: loaded only when an abort cancels a running program.
    always_ff @(posedge clk) begin
        if (!rst_n)                 rdy_cnt <= '0;
        else if (abort && busy)     rdy_cnt <= DW'(READY_CYC);
        else if (rdy_cnt != '0)     rdy_cnt <= rdy_cnt - 1'b1;
    end
endmodule

// File: rtl/pfb_sleep_timer.sv
// pfb_sleep_timer: counts samples in which the tracked vector has not
// changed and no wake event occurred; it reports sleep at the limit.
// Assumes: LIMIT >= 2.
module pfb_sleep_timer #(
    parameter int VW    = 6,
    parameter int LIMIT = 20
) (
    input  logic          clk,
    input  logic          rst_n,
    input  logic [VW-1:0] vec,
    input  logic          wake,
    output logic          stay,
    output logic          asleep
);
    localparam int CW = $clog2(LIMIT + 1);

    logic [VW-1:0] prev;
    logic [CW-1:0] cnt;

    assign stay   = (vec == prev) && !wake;
    assign asleep = (cnt == CW'(LIMIT));

    // Track the last sampled vector and the length of the stable run.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            prev <= '0;
            cnt  <= '0;
        end else begin
            prev <= vec;
            if (!stay)        cnt <= '0;
            else if (!asleep) cnt <= cnt + 1'b1;
        end
    end
endmodule

// File: rtl/pflash_bus_ctrl.sv
// pflash_bus_ctrl: host-side mode control for a parallel flash array.
// Decodes the strobes, runs the command state, holds the register-file
// array, and forms the registered read data and lane enables.
// Assumes: all pins are synchronous to clk; the pad tri-state is built
// outside from dq_out and dq_oe.
module pflash_bus_ctrl
    import pfb_pkg::*;
#(
    parameter int         AW        = 4,
    parameter int         MIN_RST   = 4,
    parameter int         READY_CYC = 10,
    parameter int         RECOV_CYC = 3,
    parameter int         SLEEP_CYC = 20,
    parameter int         PROG_CYC  = 16,
    parameter logic [7:0] MFG_CODE  = 8'h7F,
    parameter logic [7:0] DEV_CODE  = 8'hBA
) (
    input  logic          clk,
    input  logic          rst_n,
    input  logic          hw_rst_n,
    input  logic          ce_n,
    input  logic          oe_n,
    input  logic          we_n,
    input  logic          byte_n,
    input  logic [AW-1:0] addr,
    input  logic [15:0]   dq_in,
    output logic [15:0]   dq_out,
    output logic [1:0]    dq_oe,
    output logic          ready,
    output logic          sleep
);
    localparam int DEPTH = 1 << AW;
    localparam int VW    = AW + 2;

    pfb_mode_e       mode;
    logic [15:0]     mem [DEPTH];
    logic [AW-1:0]   pend_addr;
    logic [15:0]     pend_data;
    logic [1:0]      pend_mask;
    logic [15:0]     word, rd_val, rd_q;
    logic [1:0]      oe_q;
    logic            rst_acc, rd_block, prog_busy, prog_done, prog_start;
    logic            wr_cond, rd_cond, wr_q, wr_edge, cmd_ok, lane_hi;
    logic            stay, wake;

    assign wr_cond    = !ce_n && !we_n && oe_n;
    assign rd_cond    = !ce_n && !oe_n && we_n;
    assign wr_edge    = wr_cond && !wr_q;
    assign cmd_ok     = wr_edge && hw_rst_n && ready;
    assign lane_hi    = !byte_n && dq_in[15];
    assign prog_start = cmd_ok && (mode == MODE_ARMED);
    assign wake       = wr_edge || rst_acc || prog_done;

    pfb_rst_filter #(.MIN_LOW(MIN_RST), .RECOV(RECOV_CYC)) u_rst (
        .clk(clk), .rst_n(rst_n), .pin_n(hw_rst_n),
        .accept(rst_acc), .rd_block(rd_block)
    );

    pfb_busy_ctrl #(.PROG_CYC(PROG_CYC), .READY_CYC(READY_CYC)) u_busy (
        .clk(clk), .rst_n(rst_n), .start(prog_start), .abort(rst_acc),
        .busy(prog_busy), .done(prog_done), .ready(ready)
    );

    pfb_sleep_timer #(.VW(VW), .LIMIT(SLEEP_CYC)) u_sleep (
        .clk(clk), .rst_n(rst_n), .vec({byte_n, addr, lane_hi}),
        .wake(wake), .stay(stay), .asleep(sleep)
    );

    // Select the addressed word, then fit it to the bus width.
    always_comb begin
        if (mode == MODE_IDENT) word = {8'h00, addr[0] ? DEV_CODE : MFG_CODE};
        else                    word = mem[addr];
        if (byte_n) rd_val = word;
        else        rd_val = {8'h00, lane_hi ? word[15:8] : word[7:0]};
    end

    // Remember the previous write-strobe sample for edge detection.
    always_ff @(posedge clk) begin
        if (!rst_n) wr_q <= 1'b0;
        else        wr_q <= wr_cond;
    end

    // Command state: accepted resets win, then accepted writes.
    always_ff @(posedge clk) begin
        if (!rst_n)        mode <= MODE_ARRAY;
        else if (rst_acc)  mode <= MODE_ARRAY;
        else if (cmd_ok) begin
            if (mode == MODE_ARMED)              mode <= MODE_ARRAY;
            else if (dq_in[7:0] == CMD_TO_ARRAY) mode <= MODE_ARRAY;
            else if (dq_in[7:0] == CMD_TO_IDENT) mode <= MODE_IDENT;
            else if (dq_in[7:0] == CMD_ARM_PROG) mode <= MODE_ARMED;
        end
    end

    // Capture the program target and byte-lane mask at program start.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            pend_addr <= '0;
            pend_data <= '0;
            pend_mask <= '0;
        end else if (prog_start) begin
            pend_addr <= addr;
            pend_data <= byte_n ? dq_in : {dq_in[7:0], dq_in[7:0]};
            pend_mask <= byte_n ? 2'b11 : (lane_hi ? 2'b10 : 2'b01);
        end
    end

    // Register-file array: cleared at power-up, written when a program ends.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            for (int i = 0; i < DEPTH; i++) mem[i] <= '0;
        end else if (prog_done) begin
            if (pend_mask[0]) mem[pend_addr][7:0]  <= pend_data[7:0];
            if (pend_mask[1]) mem[pend_addr][15:8] <= pend_data[15:8];
        end
    end

    // Output data register: frozen while asleep, else follows the lookup.
    always_ff @(posedge clk) begin
        if (!rst_n)              rd_q <= '0;
        else if (!(sleep && stay)) rd_q <= rd_val;
    end

    // Lane drive enables: read cycle outside reset and recovery.
    always_ff @(posedge clk) begin
        if (!rst_n) oe_q <= 2'b00;
        else        oe_q <= {rd_cond && !rd_block && byte_n, rd_cond && !rd_block};
    end

    assign dq_out = rd_q;
    assign dq_oe  = oe_q;
endmodule

// File: rtl/pfb_checks.sv
// pfb_checks: temporal properties of the bus-mode controller, bound to the top.
// Assumes: RECOV_CYC >= 1 at the bound instance.
module pfb_checks #(
    parameter int AW = 4
) (
    input logic          clk,
    input logic          rst_n,
    input logic          hw_rst_n,
    input logic          byte_n,
    input logic [AW-1:0] addr,
    input logic [1:0]    dq_oe,
    input logic [15:0]   dq_out,
    input logic          ready,
    input logic          sleep,
    input logic          rst_acc,
    input logic          prog_busy
);
    a_r5_tristate_in_reset: assert property (@(posedge clk) disable iff (!rst_n)
        !hw_rst_n |=> (dq_oe == 2'b00));

    a_r10_high_lane_off: assert property (@(posedge clk) disable iff (!rst_n)
        !byte_n |=> !dq_oe[1]);

    a_r6_abort_holds_busy: assert property (@(posedge clk) disable iff (!rst_n)
        (rst_acc && prog_busy) |=> !ready);

    a_r6_idle_reset_ready: assert property (@(posedge clk) disable iff (!rst_n)
        (rst_acc && ready) |=> ready);

    a_r7_no_drive_on_release: assert property (@(posedge clk) disable iff (!rst_n)
        $rose(hw_rst_n) |=> (dq_oe == 2'b00));

    a_r9_sleep_holds_data: assert property (@(posedge clk) disable iff (!rst_n)
        (sleep && $past(sleep)) |-> $stable(dq_out));

    a_r9_wake_on_addr: assert property (@(posedge clk) disable iff (!rst_n)
        !$stable(addr) |=> !sleep);
endmodule

bind pflash_bus_ctrl pfb_checks #(.AW(AW)) u_chk (
    .clk(clk), .rst_n(rst_n), .hw_rst_n(hw_rst_n), .byte_n(byte_n),
    .addr(addr), .dq_oe(dq_oe), .dq_out(dq_out), .ready(ready),
    .sleep(sleep), .rst_acc(rst_acc), .prog_busy(prog_busy)
);

// File: tb/tb_pflash_bus_ctrl.sv
module tb_pflash_bus_ctrl;
    localparam int AW = 4, MINR = 4, RDY = 10, REC = 3, SLP = 20, PRG = 16;
    localparam int MFG = 'h7F, DEV = 'hBA;

    logic clk = 0, rst_n = 0, hw_rst_n = 1, ce_n = 1, oe_n = 1, we_n = 1, byte_n = 1;
    logic [AW-1:0] addr = '0;
    logic [15:0] dq_in = '0, dq_out;
    logic [1:0] dq_oe;
    logic ready, sleep;

    int checks = 0, errs = 0;
    bit finished = 0;

    always #4 clk = ~clk;

    pflash_bus_ctrl #(.AW(AW), .MIN_RST(MINR), .READY_CYC(RDY), .RECOV_CYC(REC),
        .SLEEP_CYC(SLP), .PROG_CYC(PRG)) dut (
        .clk(clk), .rst_n(rst_n), .hw_rst_n(hw_rst_n), .ce_n(ce_n), .oe_n(oe_n),
        .we_n(we_n), .byte_n(byte_n), .addr(addr), .dq_in(dq_in), .dq_out(dq_out),
        .dq_oe(dq_oe), .ready(ready), .sleep(sleep));

    // Behavioural reference model, advanced on every edge.
    int m_mode, m_prog, m_rdy, m_low, m_rec, m_prev, m_cnt, m_rd, m_oe;
    int m_wrq, m_pa, m_pd, m_pm;
    int m_arr [16];

    always @(posedge clk) begin
        if (!rst_n) begin
            m_mode = 0; m_prog = 0; m_rdy = 0; m_low = 0; m_rec = 0; m_prev = 0;
            m_cnt = 0; m_rd = 0; m_oe = 0; m_wrq = 0; m_pa = 0; m_pd = 0; m_pm = 0;
            foreach (m_arr[i]) m_arr[i] = 0;
        end else begin
            bit wr, rd, acc, rdy_now, done, wedge, ok, wake, lane, stay;
            int vec, w, rv;
            wr = !ce_n && !we_n && oe_n;
            rd = !ce_n && !oe_n && we_n;
            acc = !hw_rst_n && (m_low == MINR - 1);
            rdy_now = (m_prog == 0) && (m_rdy == 0);
            done = (m_prog == 1) && !acc;
            wedge = wr && !m_wrq;
            ok = wedge && hw_rst_n && rdy_now;
            lane = !byte_n && dq_in[15];
            vec = (int'(byte_n) << (AW + 1)) + (int'(addr) << 1) + int'(lane);
            wake = wedge || acc || done;
            stay = (vec == m_prev) && !wake;
            w = (m_mode == 1) ? (addr[0] ? DEV : MFG) : m_arr[addr];
            rv = byte_n ? w : (lane ? (w >> 8) & 255 : w & 255);
            if (!((m_cnt == SLP) && stay)) m_rd = rv;
            m_oe = (rd && hw_rst_n && m_rec == 0) ? (byte_n ? 3 : 1) : 0;
            if (done) begin
                if (m_pm & 1) m_arr[m_pa] = (m_arr[m_pa] & 'hFF00) | (m_pd & 'hFF);
                if (m_pm & 2) m_arr[m_pa] = (m_arr[m_pa] & 'hFF) | (m_pd & 'hFF00);
            end
            if (acc && m_prog != 0) m_rdy = RDY;
            else if (m_rdy != 0) m_rdy = m_rdy - 1;
            if (acc) begin
                m_mode = 0; m_prog = 0;
            end else begin
                if (m_prog != 0) m_prog = m_prog - 1;
                if (ok) begin
                    if (m_mode == 2) begin
                        m_pa = addr;
                        m_pd = byte_n ? dq_in : {dq_in[7:0], dq_in[7:0]};
                        m_pm = byte_n ? 3 : (lane ? 2 : 1);
                        m_prog = PRG; m_mode = 0;
                    end else if (dq_in[7:0] == 8'hF0) m_mode = 0;
                    else if (dq_in[7:0] == 8'h90) m_mode = 1;
                    else if (dq_in[7:0] == 8'hA0) m_mode = 2;
                end
            end
            m_low = hw_rst_n ? 0 : ((m_low < MINR) ? m_low + 1 : m_low);
            m_rec = !hw_rst_n ? REC : ((m_rec > 0) ? m_rec - 1 : 0);
            m_cnt = stay ? ((m_cnt < SLP) ? m_cnt + 1 : m_cnt) : 0;
            m_prev = vec;
            m_wrq = wr;
        end
    end

    task automatic chk(input string tag, input int act, input int exp);
        checks++;
        if (act != exp) begin
            errs++;
            $display("FAIL %s actual=%h expected=%h at %0t", tag, act, exp, $time);
        end
    endtask

    // Compare every output with the model shortly after each edge.
    always @(posedge clk) begin
        #2;
        if (rst_n && !finished) begin
            chk("R8 ready vs model", ready, (m_prog == 0 && m_rdy == 0));
            chk("R9 sleep vs model", sleep, (m_cnt == SLP));
            chk("R1 dq_oe vs model", dq_oe, m_oe);
            if (m_oe != 0) chk("R1 dq_out vs model", dq_out, m_rd);
        end
    end

    task automatic rd(input int a, input bit lsb);
        @(negedge clk);
        addr = a[AW-1:0]; dq_in = {lsb, 15'h0}; ce_n = 0; oe_n = 0; we_n = 1;
        @(negedge clk);
    endtask

    task automatic wr(input int a, input int d, input bit lsb);
        @(negedge clk);
        addr = a[AW-1:0];
        dq_in = byte_n ? d[15:0] : {lsb, 7'h0, d[7:0]};
        ce_n = 0; oe_n = 1; we_n = 0;
        @(negedge clk);
        ce_n = 1; we_n = 1;
    endtask

    task automatic idle(input int n);
        ce_n = 1; oe_n = 1; we_n = 1;
        repeat (n) @(negedge clk);
    endtask

    initial begin
        repeat (3) @(negedge clk);
        rst_n = 1;
        @(negedge clk);
        chk("R3 ready after reset", ready, 1);
        chk("R3 dq_oe after reset", dq_oe, 0);
        chk("R3 sleep after reset", sleep, 0);
        rd(3, 0);
        chk("R3 array cleared", dq_out, 0);
        chk("R1 read drives both lanes", dq_oe, 3);

        // Program, busy period and ignored writes.
        wr(5, 'hA0, 0); wr(5, 'h1234, 0);
        chk("R8 busy after program start", ready, 0);
        wr(6, 'hA0, 0); wr(6, 'h0055, 0);
        idle(PRG + 2);
        chk("R8 ready after program", ready, 1);
        rd(6, 0);
        chk("R8 write while busy ignored", dq_out, 0);
        rd(5, 0);
        chk("R8 programmed word", dq_out, 'h1234);

        // Identification mode.
        wr(0, 'h90, 0);
        rd(0, 0);
        chk("R11 manufacturer code", dq_out, MFG);
        rd(1, 0);
        chk("R11 device code", dq_out, DEV);
        wr(0, 'hF0, 0);
        rd(5, 0);
        chk("R2 back to array reads", dq_out, 'h1234);

        // Byte mode.
        byte_n = 0;
        rd(5, 1);
        chk("R10 high half on low lane", dq_out, 'h12);
        chk("R10 only low lane driven", dq_oe, 1);
        rd(5, 0);
        chk("R10 low half", dq_out, 'h34);
        wr(7, 'hA0, 1); wr(7, 'hAB, 1);
        idle(PRG + 2);
        byte_n = 1;
        rd(7, 0);
        chk("R10 byte program hits one lane", dq_out, 'hAB00);

        // Short reset pulse does not abort.
        idle(1);
        wr(8, 'hA0, 0); wr(8, 'h4321, 0);
        hw_rst_n = 0; repeat (MINR - 1) @(negedge clk); hw_rst_n = 1;
        chk("R4 short pulse keeps busy", ready, 0);
        idle(PRG + REC + 2);
        rd(8, 0);
        chk("R4 short pulse program completes", dq_out, 'h4321);

        // Long reset aborts a program while a read is held.
        idle(1);
        wr(9, 'hA0, 0); wr(9, 'h9999, 0);
        ce_n = 0; oe_n = 0; addr = 9;
        hw_rst_n = 0; repeat (MINR + 2) @(negedge clk);
        chk("R5 tri-state while reset held", dq_oe, 0);
        chk("R6 busy after abort", ready, 0);
        hw_rst_n = 1;
        idle(RDY + REC + 2);
        chk("R6 ready after delay", ready, 1);
        rd(9, 0);
        chk("R6 aborted word unchanged", dq_out, 0);

        // Idle reset from identification mode, write during reset, recovery.
        wr(0, 'h90, 0);
        rd(2, 0);
        chk("R11 ident before reset", dq_out, MFG);
        hw_rst_n = 0; repeat (MINR + 1) @(negedge clk);
        chk("R6 idle reset keeps ready", ready, 1);
        oe_n = 1; we_n = 0; dq_in = 'h0090; @(negedge clk);
        we_n = 1; oe_n = 0; dq_in = '0; @(negedge clk);
        hw_rst_n = 1;
        repeat (REC) @(negedge clk);
        chk("R7 no drive during recovery", dq_oe, 0);
        @(negedge clk);
        chk("R7 drive after recovery", dq_oe, 3);
        chk("R5 write in reset ignored, array reads", dq_out, 0);

        // Sleep entry and exit.
        rd(5, 0);
        repeat (SLP - 1) @(negedge clk);
        chk("R9 not yet asleep", sleep, 0);
        @(negedge clk);
        chk("R9 asleep", sleep, 1);
        chk("R9 latched data valid", dq_out, 'h1234);
        rd(6, 0);
        chk("R9 wake on address change", sleep, 0);
        chk("R9 new data after wake", dq_out, 0);

        // Reset acceptance on the final program edge.
        idle(1);
        wr(10, 'hA0, 0); wr(10, 'h7777, 0);
        repeat (PRG - MINR) @(negedge clk);
        hw_rst_n = 0;
        repeat (MINR) @(negedge clk);
        chk("R12 abort wins, busy", ready, 0);
        @(negedge clk); hw_rst_n = 1;
        idle(RDY + REC + 2);
        chk("R12 ready after delay", ready, 1);
        rd(10, 0);
        chk("R12 word unchanged", dq_out, 0);

        idle(2);
        finished = 1;
        $display("Result: errors=%0d of %0d checks", errs, checks);
        $finish;
    end

    initial begin
        repeat (200000) @(posedge clk);
        if (!finished) begin
            finished = 1;
            checks++; errs++;
            $display("FAIL R8 watchdog actual=hung expected=done");
            $display("Result: errors=%0d of %0d checks", errs, checks);
            $finish;
        end
    end
endmodule